// File: doc/BRIEF.md
# Timer Count Snapshot Latch

This block sits between four free-running 16-bit timer counters and a 32-bit register read port. Reading a live count that changes while it is read gives torn values, so every count read goes through a holding register. A read strobe with a two-bit select names one of three count words. One word carries timers 1 and 2 together. The other two words carry timer 3 and timer 4 separately. The block captures live counts into the holding registers on the strobe cycle and returns the selected word one cycle later.

A mode input picks the capture policy. With the mode low, each read captures only the timers that belong to the word being read. With the mode high, only a read of the shared timer-1/2 word captures, and it captures all four timers in the same cycle. Later reads of the timer-3 and timer-4 words then return the values frozen at that instant. This lets software take a coherent snapshot of all four timers with three reads. The counters and the bus protocol are outside this block.

Top module: `tmr_snap_latch`

## Requirements
- R1: After reset all four holding registers and `rd_data` are zero. A mode-1 read of the timer-3 word before any capture returns zero.
- R2: Mode 0 with select 0 (pair word) captures timers 1 and 2. The returned word carries timer 1 in bits 15:0 and timer 2 in bits 31:16.
- R3: Mode 0 with select 1 captures timer 3. The returned word holds the count in bits 15:0 and zero in bits 31:16.
- R4: Mode 0 with select 2 captures timer 4, using the same layout as R3.
- R5: In mode 0, a pair-word read leaves the held timer-3 and timer-4 values unchanged.
- R6: Mode 1 with select 0 captures all four live counts in the strobe cycle and returns the timer-1/2 word.
- R7: In mode 1, reads with select 1 or 2 capture nothing and return the values held from the last capture.
- R8: `rd_data` changes exactly one clock edge after a strobe, to the value captured on that edge. It holds steady while no strobe is present.
- R9: Select 3 is unmapped. It captures nothing and returns zero.
- R10: Changing the mode input does not alter any held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snap_all | input | 1 | Capture mode: 0 captures per word, 1 captures all four timers on a pair-word read |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_sel | input | 2 | Word select: 0 timers 1/2, 1 timer 3, 2 timer 4, 3 unmapped |
| cnt_live | input | 64 | Live counts: timer 1 in bits 15:0, then timers 2, 3 and 4 upward |
| rd_data | output | 32 | Registered read word |

## Verification
The reads are chosen so that the live counts differ from the held ones when the result is sampled. A stale value, a fresh value and a zero therefore each point to a different fault. The sequence first reads all three words in mode 0, then switches to mode 1 and reads timer 3 and timer 4 before any pair read. Those two reads can only return the mode-0 captures. A mode-1 pair read with new live counts is followed by timer-3 and timer-4 reads under yet other live counts, which separates a true snapshot from recapture. A final mode-0 pair read followed by a mode-1 timer-4 read shows whether the per-word policy wrongly touched timer 4.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
   typedef enum logic [1:0] {
      SEL_PAIR = 2'd0,
      SEL_T3   = 2'd1,
      SEL_T4   = 2'd2,
      SEL_NONE = 2'd3
   } rd_sel_e;

   localparam int unsigned NUM_TMR = 4;
endpackage

// File: rtl/tsl_capture_ctrl.sv
module tsl_capture_ctrl
   import tsl_pkg::*;
#(
   parameter int unsigned N_TMR = NUM_TMR
) (
   input  logic             snap_all,
   input  logic             rd_stb,
   input  logic [1:0]       rd_sel,
   output logic [N_TMR-1:0] cap_en
);
   rd_sel_e sel;

   always_comb begin
      sel    = rd_sel_e'(rd_sel);
      cap_en = '0;
      if (rd_stb) begin
         unique case (sel)
            SEL_PAIR: begin
               if (snap_all) cap_en = '1;
               else          cap_en[1:0] = 2'b11;
            end
            SEL_T3:   if (!snap_all) cap_en[2] = 1'b1;
            SEL_T4:   if (!snap_all) cap_en[3] = 1'b1;
            default:  cap_en = '0;
         endcase
      end
   end
endmodule

// File: rtl/tsl_hold_reg.sv
module tsl_hold_reg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic [W-1:0] live,
   output logic [W-1:0] held_nxt
);
   logic [W-1:0] held_q;

   assign held_nxt = cap ? live : held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) held_q <= '0;
      else        held_q <= held_nxt;
   end
endmodule

// File: rtl/tsl_read_mux.sv
module tsl_read_mux
   import tsl_pkg::*;
#(
   parameter int unsigned CW = 16,
   parameter int unsigned BW = 32
) (
   input  logic [1:0]           rd_sel,
   input  logic [NUM_TMR*CW-1:0] held,
   output logic [BW-1:0]        word
);
   always_comb begin
      word = '0;
      unique case (rd_sel_e'(rd_sel))
         SEL_PAIR: word[2*CW-1:0] = held[2*CW-1:0];
         SEL_T3:   word[CW-1:0]   = held[3*CW-1:2*CW];
         SEL_T4:   word[CW-1:0]   = held[4*CW-1:3*CW];
         default:  word = '0;
      endcase
   end
endmodule

// File: rtl/tmr_snap_latch.sv
module tmr_snap_latch
   import tsl_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned BUS_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     snap_all,
   input  logic                     rd_stb,
   input  logic [1:0]               rd_sel,
   input  logic [NUM_TMR*CNT_W-1:0] cnt_live,
   output logic [BUS_W-1:0]         rd_data
);
   localparam int unsigned ALL_W = NUM_TMR * CNT_W;

   if (CNT_W == 0) begin : g_bad_cnt
      $error("CNT_W must be nonzero");
   end
   if (BUS_W < 2 * CNT_W) begin : g_bad_bus
      $error("BUS_W must hold two counts");
   end

   logic [NUM_TMR-1:0] cap_en;
   logic [ALL_W-1:0]   held_nxt;
   logic [BUS_W-1:0]   word_nxt;

   tsl_capture_ctrl #(.N_TMR(NUM_TMR)) u_ctrl (
      .snap_all (snap_all),
      .rd_stb   (rd_stb),
      .rd_sel   (rd_sel),
      .cap_en   (cap_en)
   );

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_hold
      tsl_hold_reg #(.W(CNT_W)) u_hold (
         .clk      (clk),
         .rst_n    (rst_n),
         .cap      (cap_en[i]),
         .live     (cnt_live[i*CNT_W +: CNT_W]),
         .held_nxt (held_nxt[i*CNT_W +: CNT_W])
      );
   end

   tsl_read_mux #(.CW(CNT_W), .BW(BUS_W)) u_mux (
      .rd_sel (rd_sel),
      .held   (held_nxt),
      .word   (word_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_stb) rd_data <= word_nxt;
   end
endmodule

// File: rtl/tsl_snap_chk.sv
module tsl_snap_chk #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned BUS_W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 snap_all,
   input logic                 rd_stb,
   input logic [1:0]           rd_sel,
   input logic [4*CNT_W-1:0]   cnt_live,
   input logic [BUS_W-1:0]     rd_data
);
   // R8: no strobe, no change
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rd_data));

   // R2, R6: pair word shows live timer 1/2 from the strobe cycle
   p_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && rd_sel == 2'd0 |=>
         rd_data[2*CNT_W-1:0] == $past(cnt_live[2*CNT_W-1:0]));

   // R3: timer 3 upper bits zero, mode 0 captures live
   p_t3_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && rd_sel == 2'd1 && !snap_all |=>
         rd_data == BUS_W'($past(cnt_live[3*CNT_W-1:2*CNT_W])));

   // R4: timer 4 in mode 0
   p_t4_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && rd_sel == 2'd2 && !snap_all |=>
         rd_data == BUS_W'($past(cnt_live[4*CNT_W-1:3*CNT_W])));

   // R9: unmapped select reads zero
   p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && rd_sel == 2'd3 |=> rd_data == '0);

   // R7: repeated mode-1 timer-3 reads do not recapture
   p_norecap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      snap_all && rd_stb && rd_sel == 2'd1 &&
      $past(snap_all && rd_stb && rd_sel == 2'd1 && rst_n) |=> $stable(rd_data));
endmodule

bind tmr_snap_latch tsl_snap_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/tmr_snap_latch_test.sv
module tmr_snap_latch_test;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic        mode;
      logic [1:0]  sel;
      logic [63:0] live;   // {t4,t3,t2,t1}
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VECS [12] = '{
      '{1'b0, 2'd0, 64'h4444_3333_2222_1111, 32'h2222_1111, 4'd2},  // R2
      '{1'b0, 2'd1, 64'hdddd_cccc_bbbb_aaaa, 32'h0000_cccc, 4'd3},  // R3
      '{1'b0, 2'd2, 64'h0d0d_5a5a_0b0b_0a0a, 32'h0000_0d0d, 4'd4},  // R4
      '{1'b1, 2'd1, 64'h6666_5555_1234_4321, 32'h0000_cccc, 4'd10}, // R10
      '{1'b1, 2'd2, 64'h6767_5656_1234_4321, 32'h0000_0d0d, 4'd10}, // R10
      '{1'b1, 2'd0, 64'h0404_0303_0202_0101, 32'h0202_0101, 4'd6},  // R6
      '{1'b1, 2'd1, 64'h0c0c_0909_0808_0707, 32'h0000_0303, 4'd7},  // R7
      '{1'b1, 2'd2, 64'h0e0e_0f0f_0808_0707, 32'h0000_0404, 4'd7},  // R7
      '{1'b1, 2'd3, 64'hffff_ffff_ffff_ffff, 32'h0000_0000, 4'd9},  // R9
      '{1'b0, 2'd1, 64'h1515_7777_1313_1212, 32'h0000_7777, 4'd3},  // R3
      '{1'b0, 2'd0, 64'h2525_2424_9999_8888, 32'h9999_8888, 4'd2},  // R2
      '{1'b1, 2'd2, 64'h3535_3434_3333_3232, 32'h0000_0404, 4'd5}   // R5
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        snap_all = 1'b0;
   logic        rd_stb = 1'b0;
   logic [1:0]  rd_sel = 2'd0;
   logic [63:0] cnt_live = '0;
   logic [31:0] rd_data;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   tmr_snap_latch uut (
      .clk(clk), .rst_n(rst_n), .snap_all(snap_all), .rd_stb(rd_stb),
      .rd_sel(rd_sel), .cnt_live(cnt_live), .rd_data(rd_data)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, got, exp);
      end
   endtask

   // drive at negedge, capture at posedge, sample at the following negedge
   task automatic do_read(input logic m, input logic [1:0] s, input logic [63:0] live);
      @(negedge clk);
      snap_all = m; rd_sel = s; cnt_live = live; rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      cnt_live = ~live;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      logic [31:0] keep;
      do_reset();
      check("R1 rd_data after reset", rd_data, 32'h0);
      do_read(1'b1, 2'd1, 64'h1111_2222_3333_4444);
      check("R1 mode-1 t3 before capture", rd_data, 32'h0);

      for (int i = 0; i < 12; i++) begin
         do_read(VECS[i].mode, VECS[i].sel, VECS[i].live);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), rd_data, VECS[i].exp);
      end

      // R8: steady while idle, even with live counts moving
      keep = rd_data;
      repeat (3) begin
         @(negedge clk);
         cnt_live = cnt_live + 64'h0001_0001_0001_0001;
         snap_all = ~snap_all;
      end
      check("R8 idle hold", rd_data, keep);

      // R8: back-to-back strobes each return their own capture
      @(negedge clk);
      snap_all = 1'b0; rd_sel = 2'd1; cnt_live = 64'h0000_abcd_0000_0000; rd_stb = 1'b1;
      @(negedge clk);
      check("R8 first of pair", rd_data, 32'h0000_abcd);
      rd_sel = 2'd2; cnt_live = 64'h4321_0000_0000_0000;
      @(negedge clk);
      rd_stb = 1'b0;
      check("R8 second of pair", rd_data, 32'h0000_4321);

      // R1: reset clears held values mid-run
      do_reset();
      check("R1 rd_data after second reset", rd_data, 32'h0);
      do_read(1'b1, 2'd2, 64'h9999_9999_9999_9999);
      check("R1 held t4 cleared", rd_data, 32'h0);

      // R6: all four captured together, then read back in mode 1
      do_read(1'b1, 2'd0, 64'h4d4d_3c3c_2b2b_1a1a);
      check("R6 pair word", rd_data, 32'h2b2b_1a1a);
      do_read(1'b1, 2'd1, 64'h0);
      check("R6 t3 from snapshot", rd_data, 32'h0000_3c3c);
      do_read(1'b1, 2'd2, 64'h0);
      check("R6 t4 from snapshot", rd_data, 32'h0000_4d4d);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule